// File: doc/BRIEF.md
# Instruction Skip Pattern Sequencer

This block sits between instruction fetch and execute and applies a skip pattern to the instructions that follow a pattern-loading instruction. A pattern word of 32 bits marks up to 32 following instructions, one bit each, with the least significant bit standing for the first instruction after the loader. In cancel mode the marked instructions are still fetched, but a registered cancel flag stops their results and flags from being written. In fast mode the block tells fetch how far to advance the PC so that runs of marked instructions are never fetched.

A combined jump-and-load operation sends the PC to a target held in the low bits of its operand and loads a fast-mode pattern from the remaining high bits. Pattern use pauses while a called subroutine runs and picks up again after the matching return, with nested calls counted. Fetch applies `pc_step` (or `redirect_pc` when `redirect` is high) to the retiring instruction's PC. Instruction decode and memories are not part of this block.

Top module: `skip_sequencer`

## Requirements
- R1: After reset `cancel` and `skip_active` are 0, and any retire reports `pc_step` = 1.
- R2: Cancel mode (`load_fast` = 0): after a load with pattern P, the n-th instruction after the loader has `cancel` = 1 exactly when P[n] = 1, and every retire reports `pc_step` = 1.
- R3: A cancelled instruction still uses up one pattern bit when it retires, but its load, jump-and-load and call requests are ignored.
- R4: Fast mode (`load_fast` = 1): on each retire `pc_step` is 1 plus the number of consecutive 1 bits at the low end of the remaining pattern, the pattern moves right by that step, and `cancel` stays 0.
- R5: Fast mode takes effect only when the retiring PC is below LOCAL_SIZE (1024). At a higher PC the pattern is consumed as in cancel mode.
- R6: Jump-and-load with operand D raises `redirect` in its retire cycle with `redirect_pc` = D[9:0] + the count of consecutive low 1 bits of D[31:10]. The rest of D[31:10] becomes the fast-mode pattern for the instructions that follow the target.
- R7: A new load replaces any pattern still in progress.
- R8: `skip_active` falls to 0 once no remaining pattern bit is 1 and the current instruction is not cancelled.
- R9: After a live call retires, `cancel` stays 0, `pc_step` is 1 and loads are ignored until the matching return (calls nest). That return retire consumes the pattern, and in fast mode its `pc_step` counts the marked run after the call.
- R10: A fast-mode pattern of all ones gives `pc_step` = 33 and leaves the block inactive.
- R11: Without `retire`, `cancel` and `skip_active` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire | input | 1 | Current instruction retires this cycle |
| pc_in | input | 20 | PC of the retiring instruction |
| load_req | input | 1 | Retiring instruction loads a skip pattern |
| load_fast | input | 1 | Mode of the load: 1 fast, 0 cancel |
| exec_req | input | 1 | Retiring instruction is a jump-and-load |
| call_req | input | 1 | Retiring instruction is a subroutine call |
| ret_req | input | 1 | Retiring instruction is a subroutine return |
| operand | input | 32 | Pattern, or target plus pattern for jump-and-load |
| cancel | output | 1 | Current instruction must not commit |
| pc_step | output | 6 | PC advance for the retiring instruction |
| redirect | output | 1 | Jump-and-load redirect this cycle |
| redirect_pc | output | 20 | Target of the redirect |
| skip_active | output | 1 | A pattern is still in progress |

## Verification
Cancel mode is driven with a sparse alternating pattern to show that each bit lines up with the right instruction, counted from the loader. Fast mode uses a pattern that mixes runs of length 0, 2 and 3, so a wrong run count or wrong shift shows up as a wrong step. An all-ones word exercises the step of 33. The same fast pattern at a high PC tells the locality gate apart from the mode bit. Jump-and-load, replacement, requests made by cancelled instructions, and nested calls with a load attempted inside the subroutine each check one path where consumption or loading must not happen, or must happen at a specific retire.

// File: rtl/skip_pkg.sv
// Shared sizes and types for the skip pattern sequencer.
package skip_pkg;
    localparam int PAT_W  = 32;
    localparam int PC_W   = 20;
    localparam int TGT_W  = 10;
    localparam int STEP_W = $clog2(PAT_W + 2);

    typedef enum logic {MODE_CANCEL = 1'b0, MODE_FAST = 1'b1} skip_mode_e;
endpackage

// File: rtl/skip_lead_ones.sv
// Counts consecutive 1 bits starting at bit 0 of a vector.
// Assumes: purely combinational, any W >= 1.
module skip_lead_ones #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic run;

    // Walk from the LSB and stop counting at the first zero.
    always_comb begin
        count = '0;
        run   = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (run && vec[i]) count = count + CW'(1);
            else               run   = 1'b0;
        end
    end
endmodule

// File: rtl/skip_step_unit.sv
// Computes the PC step, the next remaining pattern and the next cancel
// flag for one consuming retire. Assumes eff_rem holds the bits of the
// instructions after the retiring one, bit 0 first.
module skip_step_unit #(
    parameter int PAT_W  = 32,
    parameter int STEP_W = 6
) (
    input  logic [PAT_W-1:0]  eff_rem,
    input  logic              fast,
    output logic [STEP_W-1:0] step,
    output logic [PAT_W-1:0]  rem_next,
    output logic              cancel_next
);
    localparam int CW = $clog2(PAT_W + 1);

    logic [CW-1:0] run_len;
    logic [CW:0]   shamt;

    skip_lead_ones #(.W(PAT_W)) u_run (.vec(eff_rem), .count(run_len));

    // Fast mode leaps the run; cancel mode steps one and flags the bit.
    always_comb begin
        shamt = {1'b0, run_len} + (CW+1)'(1);
        if (fast) begin
            step        = STEP_W'(shamt);
            rem_next    = eff_rem >> shamt;
            cancel_next = 1'b0;
        end else begin
            step        = STEP_W'(1);
            rem_next    = eff_rem >> 1;
            cancel_next = eff_rem[0];
        end
    end
endmodule

// File: rtl/skip_exec_unit.sv
// Decodes a jump-and-load operand into a redirect target and the fast
// pattern that remains after the target. Assumes the pattern's bit 0
// belongs to the instruction at the raw target address.
module skip_exec_unit #(
    parameter int PAT_W = 32,
    parameter int TGT_W = 10,
    parameter int PC_W  = 20
) (
    input  logic [PAT_W-1:0] operand,
    output logic [PC_W-1:0]  target,
    output logic [PAT_W-1:0] rem_next
);
    localparam int EW = PAT_W - TGT_W;
    localparam int CW = $clog2(EW + 1);

    logic [EW-1:0] pat;
    logic [CW-1:0] run_len;
    logic [CW:0]   shamt;

    assign pat = operand[PAT_W-1:TGT_W];

    skip_lead_ones #(.W(EW)) u_run (.vec(pat), .count(run_len));

    // Land after the marked run and keep the bits beyond the landing point.
    always_comb begin
        shamt    = {1'b0, run_len} + (CW+1)'(1);
        target   = PC_W'(operand[TGT_W-1:0]) + PC_W'(run_len);
        rem_next = PAT_W'(pat >> shamt);
    end
endmodule

// File: rtl/skip_nest_ctr.sv
// Tracks subroutine nesting depth while a skip pattern is suspended.
// Assumes inc and dec never arrive together; saturates at both ends.
module skip_nest_ctr #(
    parameter int NEST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [NEST_W-1:0] depth,
    output logic              suspended,
    output logic              last
);
    // Count calls up and returns down.
    always_ff @(posedge clk) begin
        if (!rst_n)                         depth <= '0;
        else if (inc && depth != '1)        depth <= depth + NEST_W'(1);
        else if (dec && depth != '0)        depth <= depth - NEST_W'(1);
    end

    assign suspended = (depth != '0);
    assign last      = (depth == NEST_W'(1));
endmodule

// File: rtl/skip_sequencer.sv
// Skip pattern sequencer between fetch and execute. Holds the remaining
// pattern, the mode and the cancel flag of the current instruction.
// Assumes all requests are qualified by retire of the instruction that
// issues them, and that at most one of load, exec, call, ret is set.
module skip_sequencer #(
    parameter int PC_W       = skip_pkg::PC_W,
    parameter int PAT_W      = skip_pkg::PAT_W,
    parameter int TGT_W      = skip_pkg::TGT_W,
    parameter int STEP_W     = skip_pkg::STEP_W,
    parameter int LOCAL_SIZE = 1024,
    parameter int NEST_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              load_req,
    input  logic              load_fast,
    input  logic              exec_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [PAT_W-1:0]  operand,
    output logic              cancel,
    output logic [STEP_W-1:0] pc_step,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              skip_active
);
    import skip_pkg::*;

    logic [PAT_W-1:0]  rem_q;
    skip_mode_e        mode_q;
    logic              cancel_q;
    logic [NEST_W-1:0] nest_depth;
    logic              suspended, nest_last;
    logic              live, pc_local;
    logic              do_exec, do_load, do_call, do_ret, consume;
    logic [PAT_W-1:0]  eff_rem, st_rem, ex_rem;
    logic              eff_fast, st_cancel;
    logic [STEP_W-1:0] st_step;
    logic [PC_W-1:0]   ex_target;

    // Qualify the requests of the retiring instruction.
    always_comb begin
        live     = retire && !cancel_q;
        pc_local = (pc_in < PC_W'(LOCAL_SIZE));
        do_exec  = live && exec_req && !suspended;
        do_load  = live && load_req && !exec_req && !suspended;
        do_call  = live && call_req;
        do_ret   = live && ret_req && !call_req && suspended;
        consume  = retire && ((!suspended && !do_call && !do_exec) || (do_ret && nest_last));
        eff_rem  = do_load ? operand : rem_q;
        eff_fast = (do_load ? load_fast : (mode_q == MODE_FAST)) && pc_local;
    end

    skip_nest_ctr #(.NEST_W(NEST_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .inc(do_call), .dec(do_ret),
        .depth(nest_depth), .suspended(suspended), .last(nest_last)
    );

    skip_step_unit #(.PAT_W(PAT_W), .STEP_W(STEP_W)) u_step (
        .eff_rem(eff_rem), .fast(eff_fast), .step(st_step),
        .rem_next(st_rem), .cancel_next(st_cancel)
    );

    skip_exec_unit #(.PAT_W(PAT_W), .TGT_W(TGT_W), .PC_W(PC_W)) u_exec (
        .operand(operand), .target(ex_target), .rem_next(ex_rem)
    );

    // Update the pattern, mode and cancel flag on each retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            mode_q   <= MODE_CANCEL;
            cancel_q <= 1'b0;
        end else if (do_exec) begin
            rem_q    <= ex_rem;
            mode_q   <= MODE_FAST;
            cancel_q <= 1'b0;
        end else if (consume) begin
            rem_q    <= st_rem;
            cancel_q <= st_cancel;
            if (do_load) mode_q <= load_fast ? MODE_FAST : MODE_CANCEL;
        end else if (do_call) begin
            cancel_q <= 1'b0;
        end
    end

    assign cancel      = cancel_q;
    assign pc_step     = consume ? st_step : STEP_W'(1);
    assign redirect    = do_exec;
    assign redirect_pc = ex_target;
    assign skip_active = (rem_q != '0) || cancel_q;
endmodule

// File: rtl/skip_sequencer_chk.sv
// Temporal checks on the skip sequencer, bound to every instance.
module skip_sequencer_chk #(
    parameter int PC_W       = 20,
    parameter int PAT_W      = 32,
    parameter int STEP_W     = 6,
    parameter int LOCAL_SIZE = 1024,
    parameter int NEST_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire,
    input logic [PC_W-1:0]   pc_in,
    input logic              load_req,
    input logic              load_fast,
    input logic              exec_req,
    input logic              call_req,
    input logic              cancel,
    input logic [STEP_W-1:0] pc_step,
    input logic              redirect,
    input logic              skip_active,
    input logic [NEST_W-1:0] depth
);
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (pc_step >= STEP_W'(1) && pc_step <= STEP_W'(PAT_W + 1)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> ($stable(cancel) && $stable(skip_active)));

    assert_no_cancel_in_call_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (depth != '0) |-> !cancel);

    assert_deep_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && depth > NEST_W'(1)) |-> (pc_step == STEP_W'(1)));

    assert_fast_no_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !cancel && load_req && load_fast && !exec_req && !call_req
         && depth == '0 && pc_in < PC_W'(LOCAL_SIZE)) |=> !cancel);

    assert_exec_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !cancel);
endmodule

bind skip_sequencer skip_sequencer_chk #(
    .PC_W(PC_W), .PAT_W(PAT_W), .STEP_W(STEP_W),
    .LOCAL_SIZE(LOCAL_SIZE), .NEST_W(NEST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .retire(retire), .pc_in(pc_in),
    .load_req(load_req), .load_fast(load_fast), .exec_req(exec_req),
    .call_req(call_req), .cancel(cancel), .pc_step(pc_step),
    .redirect(redirect), .skip_active(skip_active), .depth(nest_depth)
);

// File: tb/tb_skip_sequencer.sv
module tb_skip_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire = 1'b0, load_req = 1'b0, load_fast = 1'b0;
    logic        exec_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic [19:0] pc_in = '0;
    logic [31:0] operand = '0;
    logic        cancel, redirect, skip_active;
    logic [5:0]  pc_step;
    logic [19:0] redirect_pc;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [5:0]  cap_step;
    logic        cap_redir;
    logic [19:0] cap_rpc;

    skip_sequencer dut (
        .clk(clk), .rst_n(rst_n), .retire(retire), .pc_in(pc_in),
        .load_req(load_req), .load_fast(load_fast), .exec_req(exec_req),
        .call_req(call_req), .ret_req(ret_req), .operand(operand),
        .cancel(cancel), .pc_step(pc_step), .redirect(redirect),
        .redirect_pc(redirect_pc), .skip_active(skip_active)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One retire: kind 0 plain, 1 load, 2 exec, 3 call, 4 ret.
    task automatic issue(input int kind, input logic fast, input logic [31:0] op, input logic [19:0] pc);
        @(negedge clk);
        retire = 1'b1; pc_in = pc; operand = op; load_fast = fast;
        load_req = (kind == 1); exec_req = (kind == 2);
        call_req = (kind == 3); ret_req = (kind == 4);
        #1;
        cap_step = pc_step; cap_redir = redirect; cap_rpc = redirect_pc;
        @(posedge clk); #1;
        retire = 1'b0; load_req = 1'b0; exec_req = 1'b0;
        call_req = 1'b0; ret_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cancel after reset", cancel, 0);
        check("R1 active after reset", skip_active, 0);
        issue(0, 0, 0, 20'h5);
        check("R1 step", cap_step, 1);
    endtask

    task automatic t_cancel_mode();
        issue(1, 0, 32'h5, 20'h10);
        check("R2 loader step", cap_step, 1);
        check("R2 inst0 cancel", cancel, 1);
        repeat (3) @(posedge clk);
        #1 check("R11 cancel held while idle", cancel, 1);
        issue(0, 0, 0, 20'h11);
        check("R2 inst1 cancel", cancel, 0);
        issue(0, 0, 0, 20'h12);
        check("R2 step", cap_step, 1);
        check("R2 inst2 cancel", cancel, 1);
        issue(0, 0, 0, 20'h13);
        check("R2 inst3 cancel", cancel, 0);
        check("R8 inactive", skip_active, 0);
    endtask

    task automatic t_cancelled_requests();
        issue(1, 0, 32'h1, 20'h20);
        check("R3 setup cancel", cancel, 1);
        issue(1, 1, 32'hFFFF_FFFF, 20'h21);
        check("R3 cancelled load ignored", skip_active, 0);
        check("R3 cancelled load step", cap_step, 1);
        issue(1, 0, 32'h1, 20'h22);
        issue(2, 0, 32'h0000_0155, 20'h23);
        check("R3 cancelled exec no redirect", cap_redir, 0);
        check("R3 bit consumed", skip_active, 0);
    endtask

    task automatic t_fast_mode();
        issue(1, 1, 32'h0000_00E6, 20'h40);
        check("R4 loader step", cap_step, 1);
        check("R4 no cancel", cancel, 0);
        issue(0, 0, 0, 20'h41);
        check("R4 run of two", cap_step, 3);
        issue(0, 0, 0, 20'h44);
        check("R4 run of zero", cap_step, 1);
        issue(0, 0, 0, 20'h45);
        check("R4 run of three", cap_step, 4);
        check("R8 fast done", skip_active, 0);
    endtask

    task automatic t_hub_fallback();
        issue(1, 1, 32'h6, 20'h800);
        check("R5 hub loader step", cap_step, 1);
        check("R5 inst0 cancel", cancel, 0);
        issue(0, 0, 0, 20'h801);
        check("R5 hub step", cap_step, 1);
        check("R5 inst1 cancel", cancel, 1);
        issue(0, 0, 0, 20'h802);
        check("R5 inst2 cancel", cancel, 1);
        issue(0, 0, 0, 20'h803);
        check("R5 inst3 cancel", cancel, 0);
    endtask

    task automatic t_exec();
        issue(2, 0, 32'h0000_2D23, 20'h60);
        check("R6 redirect", cap_redir, 1);
        check("R6 target", cap_rpc, 20'h125);
        check("R6 no cancel", cancel, 0);
        issue(0, 0, 0, 20'h125);
        check("R6 pattern continues", cap_step, 2);
        check("R6 done", skip_active, 0);
    endtask

    task automatic t_replace();
        issue(1, 0, 32'h2, 20'h70);
        issue(1, 0, 32'h0, 20'h71);
        check("R7 replaced cancel", cancel, 0);
        check("R7 replaced active", skip_active, 0);
    endtask

    task automatic t_all_ones();
        issue(1, 1, 32'hFFFF_FFFF, 20'h90);
        check("R10 step", cap_step, 33);
        check("R10 inactive", skip_active, 0);
    endtask

    task automatic t_call();
        issue(1, 0, 32'h2, 20'hA0);
        issue(3, 0, 0, 20'hA1);
        check("R9 call no cancel", cancel, 0);
        issue(0, 0, 0, 20'h300);
        check("R9 sub step", cap_step, 1);
        issue(1, 0, 32'hFFFF_FFFF, 20'h301);
        issue(3, 0, 0, 20'h302);
        issue(0, 0, 0, 20'h380);
        issue(4, 0, 0, 20'h381);
        check("R9 inner return keeps pause", cancel, 0);
        issue(4, 0, 0, 20'h303);
        check("R9 resume cancel", cancel, 1);
        issue(0, 0, 0, 20'hA2);
        check("R9 sub load ignored", skip_active, 0);
        issue(1, 1, 32'h6, 20'hB0);
        issue(3, 0, 0, 20'hB1);
        issue(0, 0, 0, 20'h300);
        issue(4, 0, 0, 20'h301);
        check("R9 fast resume step", cap_step, 3);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cancel_mode();
        t_cancelled_requests();
        t_fast_mode();
        t_hub_fallback();
        t_exec();
        t_replace();
        t_all_ones();
        t_call();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule